// File: doc/BRIEF.md
# Fabric Clear Sequencer

This block wipes the programmable fabric before a new configuration image is streamed in. A single start pulse launches a fixed three-phase handshake on the active-low program line. The block watches the fabric's INIT status line throughout the handshake. It ends in one of two ways: it reports ready, or it reports an error with a code that names the phase that failed.

The first phase releases the program line. It waits for INIT to be high, and if INIT is already high it moves on at once. The second phase pulls the program line low. INIT is then polled at a fixed spacing of microsecond ticks, and the number of polls is bounded. In the third phase the line is released again, and the block waits for INIT to rise, which signals that the fabric has finished its internal initialisation. The waits in phases one and three are each limited to a timeout counted in microsecond ticks.

On success the block gives a one-cycle pulse. Sticky status flags elsewhere, including a stale done indication, clear on that pulse.

Top module: `fab_clr_seq`

## Requirements
- R1: After reset prog_o is 1, busy_o, ready_o, error_o and clr_sticky_o are 0, and err_code_o is 0.
- R2: A start_i pulse while not busy begins phase one. In phase one prog_o is 1, and the block leaves phase one on the first cycle in which synchronised INIT is high, without waiting for an edge when INIT is already high.
- R3: If synchronised INIT is not high within TIMEOUT_US ticks of entering phase one, the sequence ends with error_o=1 and err_code_o=1.
- R4: In phase two prog_o is 0, and INIT is checked once every POLL_GAP_US ticks. The first check that finds synchronised INIT low moves the block to phase three.
- R5: If synchronised INIT is still high at the POLL_TRIES-th check, the sequence ends with error_o=1 and err_code_o=2.
- R6: In phase three prog_o is 1. A rising edge of synchronised INIT ends the sequence with ready_o=1 and err_code_o=0.
- R7: If no rising edge arrives within TIMEOUT_US ticks of entering phase three, the sequence ends with error_o=1 and err_code_o=3.
- R8: init_i passes through a two-flop synchroniser. Every decision uses the level two clocks old, and edges are detected on that synchronised level.
- R9: start_i is ignored while busy_o is 1.
- R10: ready_o and error_o are never both 1. Each holds, together with err_code_o, until the next start_i, which clears it.
- R11: clr_sticky_o is a single-cycle pulse in the first cycle of ready_o. It is never raised on an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| init_i | input | 1 | Fabric INIT status level, asynchronous |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| prog_o | output | 1 | Program line level, low holds the fabric in clear |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Sequence completed |
| error_o | output | 1 | Sequence failed |
| err_code_o | output | 2 | 1 phase-one timeout, 2 release poll failed, 3 phase-three timeout |
| clr_sticky_o | output | 1 | Pulse to clear sticky status flags |

## Verification
The bench builds the block with TIMEOUT_US=40, POLL_GAP_US=2 and POLL_TRIES=4, and sends a tick every fourth clock. With these values both timeouts, the exhaustion of the release poll and the poll spacing all occur within a few hundred cycles, so each error code is reached. Successful runs are driven with INIT already high at start and with INIT rising late.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_CLEAR, ST_INIT_WAIT, ST_READY, ST_FAIL
  } fcs_state_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_ARM_TMO  = 2'd1,
    ERR_RELEASE  = 2'd2,
    ERR_INIT_TMO = 2'd3
  } fcs_err_e;
endpackage

// File: rtl/fcs_sync.sv
module fcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/fcs_edge.sv
module fcs_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/fcs_tick_timer.sv
module fcs_tick_timer #(
  parameter int LIMIT = 5,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = (cnt_q == W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (tick_i && !hit_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fab_clr_seq.sv
module fab_clr_seq
  import fcs_pkg::*;
#(
  parameter int TIMEOUT_US  = 1000000,
  parameter int POLL_GAP_US = 5,
  parameter int POLL_TRIES  = 100,
  parameter int SYNC_STAGES = 2,
  localparam int TRY_W = $clog2(POLL_TRIES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       init_i,
  input  logic       us_tick_i,
  output logic       prog_o,
  output logic       busy_o,
  output logic       ready_o,
  output logic       error_o,
  output logic [1:0] err_code_o,
  output logic       clr_sticky_o
);
  fcs_state_e state_q, state_d;
  fcs_err_e   err_q, err_d;
  logic [TRY_W-1:0] tries_q, tries_d;
  logic init_s, init_rise, tmo_hit, gap_hit, gap_clr, tmo_clr;
  logic pulse_q;

  fcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(init_i), .q_o(init_s)
  );

  fcs_edge u_edge (
    .clk_i, .rst_ni, .lvl_i(init_s), .rise_o(init_rise)
  );

  fcs_tick_timer #(.LIMIT(TIMEOUT_US)) u_tmo (
    .clk_i, .rst_ni, .clr_i(tmo_clr), .tick_i(us_tick_i), .hit_o(tmo_hit)
  );

  fcs_tick_timer #(.LIMIT(POLL_GAP_US)) u_gap (
    .clk_i, .rst_ni, .clr_i(gap_clr), .tick_i(us_tick_i), .hit_o(gap_hit)
  );

  // timeout restarts on every phase change; poll gap restarts after each check
  assign tmo_clr = (state_d != state_q);
  assign gap_clr = (state_q != ST_CLEAR) || gap_hit;

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    tries_d = tries_q;
    unique case (state_q)
      ST_IDLE, ST_READY, ST_FAIL: begin
        if (start_i) begin
          state_d = ST_ARM;
          err_d   = ERR_NONE;
        end
      end
      ST_ARM: begin
        if (init_s) begin
          state_d = ST_CLEAR;
          tries_d = '0;
        end else if (tmo_hit) begin
          state_d = ST_FAIL;
          err_d   = ERR_ARM_TMO;
        end
      end
      ST_CLEAR: begin
        if (gap_hit) begin
          if (!init_s) begin
            state_d = ST_INIT_WAIT;
          end else if (tries_q == TRY_W'(POLL_TRIES - 1)) begin
            state_d = ST_FAIL;
            err_d   = ERR_RELEASE;
          end else begin
            tries_d = tries_q + 1'b1;
          end
        end
      end
      ST_INIT_WAIT: begin
        if (init_rise) begin
          state_d = ST_READY;
        end else if (tmo_hit) begin
          state_d = ST_FAIL;
          err_d   = ERR_INIT_TMO;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= ERR_NONE;
      tries_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      tries_q <= tries_d;
      pulse_q <= (state_q == ST_INIT_WAIT) && (state_d == ST_READY);
    end
  end

  assign prog_o       = (state_q != ST_CLEAR);
  assign busy_o       = (state_q == ST_ARM) || (state_q == ST_CLEAR) ||
                        (state_q == ST_INIT_WAIT);
  assign ready_o      = (state_q == ST_READY);
  assign error_o      = (state_q == ST_FAIL);
  assign err_code_o   = err_q;
  assign clr_sticky_o = pulse_q;
endmodule

// File: rtl/fab_clr_seq_chk.sv
module fab_clr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       prog_o,
  input logic       busy_o,
  input logic       ready_o,
  input logic       error_o,
  input logic [1:0] err_code_o,
  input logic       clr_sticky_o
);
  // R10
  excl_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && error_o));

  // R4
  prog_low_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_o |-> busy_o);

  // R11
  pulse_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_sticky_o |-> (ready_o && !error_o));

  // R11
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_sticky_o |=> !clr_sticky_o);

  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R10
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ready_o);

  // R10
  error_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> (error_o && $stable(err_code_o)));

  // R6
  ready_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (err_code_o == 2'd0));
endmodule

bind fab_clr_seq fab_clr_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .prog_o(prog_o),
  .busy_o(busy_o), .ready_o(ready_o), .error_o(error_o),
  .err_code_o(err_code_o), .clr_sticky_o(clr_sticky_o)
);

// File: tb/fab_clr_seq_tb_top.sv
module fab_clr_seq_tb_top;
  localparam int T_US = 40;
  localparam int GAP  = 2;
  localparam int TRY  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, init_i = 1'b0, us_tick_i = 1'b0;
  logic prog_o, busy_o, ready_o, error_o, clr_sticky_o;
  logic [1:0] err_code_o;

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  bit finished = 1'b0;
  logic init_lvl = 1'b0;

  always #5 clk_i = ~clk_i;

  fab_clr_seq #(.TIMEOUT_US(T_US), .POLL_GAP_US(GAP), .POLL_TRIES(TRY)) dut_i (
    .clk_i, .rst_ni, .start_i, .init_i, .us_tick_i, .prog_o, .busy_o,
    .ready_o, .error_o, .err_code_o, .clr_sticky_o
  );

  // behavioural reference: phase numbers 0 idle,1 arm,2 clear,3 wait,4 ready,5 fail
  int m_ph, m_code, m_tmo, m_gap, m_try;
  bit m_pulse;
  bit dly[$];
  bit m_prev;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_code = 0; m_tmo = 0; m_gap = 0; m_try = 0; m_pulse = 0;
      dly = '{0, 0}; m_prev = 0;
    end else begin
      bit lvl, up, th, gh;
      int nph;
      lvl = dly[0];
      up  = lvl && !m_prev;
      th  = (m_tmo == T_US);
      gh  = (m_gap == GAP);
      nph = m_ph;
      case (m_ph)
        0, 4, 5: if (start_i) begin nph = 1; m_code = 0; end
        1: if (lvl) begin nph = 2; m_try = 0; end
           else if (th) begin nph = 5; m_code = 1; end
        2: if (gh) begin
             if (!lvl) nph = 3;
             else if (m_try == TRY - 1) begin nph = 5; m_code = 2; end
             else m_try++;
           end
        3: if (up) nph = 4;
           else if (th) begin nph = 5; m_code = 3; end
        default: ;
      endcase
      m_pulse = (m_ph == 3) && (nph == 4);
      if (nph != m_ph) m_tmo = 0;
      else if (us_tick_i && !th) m_tmo++;
      if (m_ph != 2 || gh) m_gap = 0;
      else if (us_tick_i && !gh) m_gap++;
      m_ph = nph;
      m_prev = lvl;
      void'(dly.pop_front());
      dly.push_back(init_i);
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic step(bit st);
    @(negedge clk_i);
    if (rst_ni) begin
      chk("R1/R4 prog", prog_o, (m_ph != 2));
      chk("R9 busy", busy_o, (m_ph >= 1 && m_ph <= 3));
      chk("R10 ready", ready_o, (m_ph == 4));
      chk("R10 error", error_o, (m_ph == 5));
      chk("R3/R5/R7 code", err_code_o, m_code);
      chk("R11 pulse", clr_sticky_o, m_pulse);
      if (clr_sticky_o) pulses++;
    end
    start_i   = st;
    init_i    = init_lvl;
    us_tick_i = ((cyc % 4) == 3);
    cyc++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    run(3);
    rst_ni = 1'b1;
    run(2);
    // R1 reset state
    chk("R1 prog", prog_o, 1); chk("R1 busy", busy_o, 0);
    chk("R1 ready", ready_o, 0); chk("R1 error", error_o, 0);
    chk("R1 code", err_code_o, 0);

    // S1: R2 INIT already high, R4 poll, R6 edge, R9 ignored start
    init_lvl = 1'b1; run(8);
    step(1'b1); run(4);
    chk("R2 phase1 passed at once", prog_o, 0);
    run(12); init_lvl = 1'b0; run(30);
    chk("R4 reached phase3", busy_o & prog_o, 1);
    step(1'b1); run(3);
    chk("R9 start ignored busy", busy_o, 1);
    init_lvl = 1'b1; run(8);
    chk("R6 ready", ready_o, 1); chk("R6 code", err_code_o, 0);
    chk("R11 one pulse", pulses, 1);

    // S2: R2 late INIT in phase one, R10 restart clears ready
    init_lvl = 1'b0; run(6);
    step(1'b1); run(20);
    chk("R10 ready cleared by start", ready_o, 0);
    chk("R2 waiting prog high", prog_o, 1);
    init_lvl = 1'b1; run(6);
    chk("R8 phase2 after sync", prog_o, 0);
    init_lvl = 1'b0; run(20); init_lvl = 1'b1; run(8);
    chk("R6 ready again", ready_o, 1);

    // S3: R3 phase-one timeout
    init_lvl = 1'b0; run(6);
    step(1'b1); run(T_US * 4 + 20);
    chk("R3 error", error_o, 1); chk("R3 code", err_code_o, 1);
    chk("R11 no pulse on error", pulses, 2);

    // S4: R5 release poll exhausted
    init_lvl = 1'b1; run(6);
    step(1'b1); run(GAP * 4 * TRY + 20);
    chk("R5 error", error_o, 1); chk("R5 code", err_code_o, 2);

    // S5: R7 phase-three timeout
    step(1'b1); run(14); init_lvl = 1'b0; run(T_US * 4 + 30);
    chk("R7 error", error_o, 1); chk("R7 code", err_code_o, 3);
    run(20);
    chk("R10 error held", error_o, 1); chk("R10 code held", err_code_o, 3);
    step(1'b1); run(2);
    chk("R10 error cleared by start", error_o, 0);
    chk("R10 busy after start", busy_o, 1);
    run(4);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule